// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter rebuilt as a multiple-input, multiple-output datapath. Each accepted clock cycle takes a block of three consecutive samples and produces the three matching filter outputs. The sample rate is therefore three times the clock rate, while the longest combinational path stays one multiply followed by two adds, the same as in a one-sample-per-clock filter.

The multiply-add network is built three times, once per output lane. Each lane looks at a window of the current block's samples and, where the window reaches back past the start of the block, at the last two samples of the previous accepted block. Those two samples are kept in a small history register. The coefficients are plain inputs and are used in the cycle in which a block is accepted. Outputs are registered. Conversion between a serial stream and sample blocks is done outside the block.

Top module: `fir3p_block`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is cleared, every output lane is cleared to zero and the history is cleared. An input block offered during reset is not taken into the history. The first block accepted after reset therefore sees zero for both earlier samples.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge, so there is one cycle of latency.
- R3: Output lane 0 equals a·x0 + b·xp1 + c·xp2. Here x0 is lane 0 of the accepted block, and xp1 and xp2 are lanes 2 and 1 of the previous accepted block. Lane 0 is the oldest sample of a block and lane 2 the newest. Coefficient slot 0 is a, slot 1 is b and slot 2 is c.
- R4: Output lane 1 equals a·x1 + b·x0 + c·xp1.
- R5: Output lane 2 equals a·x2 + b·x1 + c·x0, using only the current block.
- R6: The history is loaded only when `in_valid` is high. Samples offered in idle cycles do not appear in later results.
- R7: In a cycle after `in_valid` was low, every output lane keeps its previous value.
- R8: Samples and coefficients are signed two's complement, 16 bits each. Outputs are signed, 34 bits, and never overflow, including the case where all operands are -32768.
- R9: Each block is filtered with the coefficients present in the cycle in which it is accepted. A coefficient change between blocks takes effect on the very next block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input block is present this cycle |
| in_lane | input | 3x16 | Sample block; lane 0 is the oldest sample |
| coef | input | 3x16 | Coefficients a, b, c in slots 0, 1, 2 |
| out_valid | output | 1 | Output lanes hold a new block |
| out_lane | output | 3x34 | Filter outputs for the block, lane 0 oldest |

## Verification
Every result of an accepted block is due one clock edge after the edge that accepts it. The history used by the next block also updates on that same edge. The bench drives a block on a falling edge and compares all three lanes and the valid flag on the following falling edge. By then exactly one rising edge has passed. The expected values come from a one-sample-at-a-time filter run over the interleaved stream. Idle cycles are checked against the held values from the last accepted block.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;

    // Datapath dimensions
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int BLOCK_N  = 3;
    localparam int TAP_N    = 3;

    // Derived: enough guard bits for TAP_N full-precision products
    localparam int PROD_W   = SAMPLE_W + COEF_W;
    localparam int ACC_W    = PROD_W + $clog2(TAP_N);
    localparam int KEEP_N   = TAP_N - 1;
    localparam int IDX_W    = 8;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    // Where a tap of an output lane fetches its sample from
    typedef enum logic {
        SRC_CUR  = 1'b0,
        SRC_HIST = 1'b1
    } src_e;

    typedef struct packed {
        src_e             kind;
        logic [IDX_W-1:0] idx;
    } tap_ref_t;

    // Tap t of lane j needs x(n - t) with n = base + j.
    // Non-negative offsets stay in the current block; negative ones
    // reach into the history (index 0 = one sample before the block).
    function automatic tap_ref_t locate(int lane, int tap);
        tap_ref_t r;
        int pos;
        pos = lane - tap;
        if (pos >= 0) begin
            r.kind = SRC_CUR;
            r.idx  = IDX_W'(pos);
        end else begin
            r.kind = SRC_HIST;
            r.idx  = IDX_W'(-pos - 1);
        end
        return r;
    endfunction

    // Full-precision signed product widened to accumulator width
    function automatic acc_t scaled(sample_t s, coef_t c);
        return acc_t'(s) * acc_t'(c);
    endfunction

endpackage

// File: rtl/fir3p_history.sv
module fir3p_history
    import fir3p_pkg::*;
#(
    parameter int BLK  = BLOCK_N,
    parameter int TAPS = TAP_N
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sample_t blk  [BLK],
    output sample_t past [TAPS-1]
);
    localparam int KEEP = TAPS - 1;

    sample_t past_q [KEEP];

    // past_q[i] holds the sample i+1 positions before the current block
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < KEEP; i++) begin
                past_q[i] <= '0;
            end
        end else if (load) begin
            for (int i = 0; i < KEEP; i++) begin
                past_q[i] <= blk[BLK-1-i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < KEEP; i++) begin
            past[i] = past_q[i];
        end
    end

endmodule

// File: rtl/fir3p_lane_mac.sv
module fir3p_lane_mac
    import fir3p_pkg::*;
#(
    parameter int TAPS = TAP_N
) (
    input  sample_t win  [TAPS],
    input  coef_t   taps [TAPS],
    output acc_t    y
);
    acc_t sum;

    // win[t] is x(n - t); taps[t] is its weight
    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum = sum + scaled(win[t], taps[t]);
        end
        y = sum;
    end

endmodule

// File: rtl/fir3p_out_reg.sv
module fir3p_out_reg
    import fir3p_pkg::*;
#(
    parameter int BLK = BLOCK_N
) (
    input  logic clk,
    input  logic rst,
    input  logic vld_in,
    input  acc_t y_in  [BLK],
    output logic vld_q,
    output acc_t y_q   [BLK]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            for (int j = 0; j < BLK; j++) begin
                y_q[j] <= '0;
            end
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                for (int j = 0; j < BLK; j++) begin
                    y_q[j] <= y_in[j];
                end
            end
        end
    end

endmodule

// File: rtl/fir3p_block.sv
module fir3p_block
    import fir3p_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic [BLOCK_N-1:0][SAMPLE_W-1:0]   in_lane,
    input  logic [TAP_N-1:0][COEF_W-1:0]       coef,
    output logic                               out_valid,
    output logic [BLOCK_N-1:0][ACC_W-1:0]      out_lane
);
    sample_t cur    [BLOCK_N];
    coef_t   cf     [TAP_N];
    sample_t past   [KEEP_N];
    acc_t    lane_y [BLOCK_N];
    acc_t    held_y [BLOCK_N];

    for (genvar i = 0; i < BLOCK_N; i++) begin : g_unpack_in
        assign cur[i] = sample_t'(in_lane[i]);
    end

    for (genvar t = 0; t < TAP_N; t++) begin : g_unpack_coef
        assign cf[t] = coef_t'(coef[t]);
    end

    fir3p_history #(
        .BLK  (BLOCK_N),
        .TAPS (TAP_N)
    ) u_hist (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .blk  (cur),
        .past (past)
    );

    // One replicated multiply-add per output lane
    for (genvar j = 0; j < BLOCK_N; j++) begin : g_lane
        sample_t win [TAP_N];

        for (genvar t = 0; t < TAP_N; t++) begin : g_tap
            localparam tap_ref_t REF = locate(j, t);
            if (REF.kind == SRC_CUR) begin : g_cur
                assign win[t] = cur[REF.idx];
            end else begin : g_hist
                assign win[t] = past[REF.idx];
            end
        end

        fir3p_lane_mac #(
            .TAPS (TAP_N)
        ) u_mac (
            .win  (win),
            .taps (cf),
            .y    (lane_y[j])
        );
    end

    fir3p_out_reg #(
        .BLK (BLOCK_N)
    ) u_oreg (
        .clk    (clk),
        .rst    (rst),
        .vld_in (in_valid),
        .y_in   (lane_y),
        .vld_q  (out_valid),
        .y_q    (held_y)
    );

    for (genvar j = 0; j < BLOCK_N; j++) begin : g_pack_out
        assign out_lane[j] = held_y[j];
    end

endmodule

// File: rtl/fir3p_block_chk.sv
module fir3p_block_chk
    import fir3p_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             in_valid,
    input logic [BLOCK_N-1:0][SAMPLE_W-1:0] in_lane,
    input logic [TAP_N-1:0][COEF_W-1:0]     coef,
    input logic                             out_valid,
    input logic [BLOCK_N-1:0][ACC_W-1:0]    out_lane
);
    // Shadow of the previous accepted block's newest two samples
    sample_t sh_m1, sh_m2;
    sample_t x0, x1, x2;
    coef_t   ca, cb, cc;
    acc_t    e0, e1, e2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_m1 <= '0;
            sh_m2 <= '0;
        end else if (in_valid) begin
            sh_m1 <= sample_t'(in_lane[2]);
            sh_m2 <= sample_t'(in_lane[1]);
        end
    end

    assign x0 = sample_t'(in_lane[0]);
    assign x1 = sample_t'(in_lane[1]);
    assign x2 = sample_t'(in_lane[2]);
    assign ca = coef_t'(coef[0]);
    assign cb = coef_t'(coef[1]);
    assign cc = coef_t'(coef[2]);

    assign e0 = scaled(x0, ca) + scaled(sh_m1, cb) + scaled(sh_m2, cc);
    assign e1 = scaled(x1, ca) + scaled(x0, cb)    + scaled(sh_m1, cc);
    assign e2 = scaled(x2, ca) + scaled(x1, cb)    + scaled(x0, cc);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_lane == '0));

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_lane0_value_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (out_lane[0] == $past(e0)));

    assert_lane1_value_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (out_lane[1] == $past(e1)));

    assert_lane2_value_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (out_lane[2] == $past(e2)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_lane));

endmodule

bind fir3p_block fir3p_block_chk u_chk (.*);

// File: tb/sim_fir3p_block.sv
module sim_fir3p_block;
    import fir3p_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                             rst;
    logic                             in_valid;
    logic [BLOCK_N-1:0][SAMPLE_W-1:0] in_lane;
    logic [TAP_N-1:0][COEF_W-1:0]     coef;
    logic                             out_valid;
    logic [BLOCK_N-1:0][ACC_W-1:0]    out_lane;

    fir3p_block u0 (.*);

    int     checks = 0;
    int     fails  = 0;
    longint stream [$];
    longint exp_y  [BLOCK_N];
    logic   exp_v;
    string  lane_req [BLOCK_N] = '{"R3", "R4", "R5"};

    task automatic check(string req, longint act, longint expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic longint rnd_s16();
        logic signed [15:0] v;
        v = 16'($urandom);
        return longint'(v);
    endfunction

    function automatic longint xs(int i);
        return (i < 0) ? 0 : stream[i];
    endfunction

    // Sample-serial reference: y(n) = a x(n) + b x(n-1) + c x(n-2)
    function automatic longint ref_y(int n, longint a, longint b, longint c);
        return a * xs(n) + b * xs(n - 1) + c * xs(n - 2);
    endfunction

    // Called just after a falling edge; checks on the next falling edge
    task automatic apply(bit v, longint s [BLOCK_N], longint c [TAP_N], string extra);
        int base;
        in_valid = v;
        for (int j = 0; j < BLOCK_N; j++) in_lane[j] = SAMPLE_W'(s[j]);
        for (int t = 0; t < TAP_N; t++)   coef[t]    = COEF_W'(c[t]);
        if (v) begin
            for (int j = 0; j < BLOCK_N; j++) stream.push_back(s[j]);
            base = stream.size() - BLOCK_N;
            for (int j = 0; j < BLOCK_N; j++) exp_y[j] = ref_y(base + j, c[0], c[1], c[2]);
        end
        exp_v = v;
        @(posedge clk);
        @(negedge clk);
        check({"R2", extra}, longint'(out_valid), longint'(exp_v));
        for (int j = 0; j < BLOCK_N; j++) begin
            check(v ? {lane_req[j], extra} : {"R7", extra},
                  longint'($signed(out_lane[j])), exp_y[j]);
        end
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b1;              // junk block during reset must be dropped (R1)
        for (int j = 0; j < BLOCK_N; j++) in_lane[j] = SAMPLE_W'(rnd_s16());
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 valid", longint'(out_valid), 0);
        for (int j = 0; j < BLOCK_N; j++) check("R1 lane", longint'($signed(out_lane[j])), 0);
        rst      = 1'b0;
        in_valid = 1'b0;
        stream.delete();
        for (int j = 0; j < BLOCK_N; j++) exp_y[j] = 0;
        exp_v = 1'b0;
    endtask

    task automatic run_all();
        longint s [BLOCK_N];
        longint c [TAP_N];
        longint prev_idle;

        coef = '0;
        do_reset();

        // First block after reset sees zero history (R1)
        c = '{3, -5, 7};
        apply(1'b1, '{100, -200, 300}, c, "/R1 first");

        // Continuous blocks, fixed coefficients (R3 R4 R5)
        c = '{rnd_s16(), rnd_s16(), rnd_s16()};
        for (int k = 0; k < 40; k++) begin
            s = '{rnd_s16(), rnd_s16(), rnd_s16()};
            apply(1'b1, s, c, "");
        end

        // Gapped traffic: idle cycles carry junk lanes and junk coefs (R6 R7)
        prev_idle = 0;
        for (int k = 0; k < 80; k++) begin
            bit v;
            v = ($urandom % 2) == 0;
            s = '{rnd_s16(), rnd_s16(), rnd_s16()};
            if (v) begin
                apply(1'b1, s, c, (prev_idle != 0) ? "/R6" : "");
                prev_idle = 0;
            end else begin
                apply(1'b0, s, '{rnd_s16(), rnd_s16(), rnd_s16()}, "/R6 idle");
                prev_idle = 1;
            end
        end

        // Coefficients change every block (R9)
        for (int k = 0; k < 30; k++) begin
            s = '{rnd_s16(), rnd_s16(), rnd_s16()};
            c = '{rnd_s16(), rnd_s16(), rnd_s16()};
            apply(1'b1, s, c, "/R9");
        end

        // Extreme operands, full-range signed products (R8)
        apply(1'b1, '{-32768, -32768, -32768}, '{-32768, -32768, -32768}, "/R8");
        apply(1'b1, '{-32768, -32768, -32768}, '{-32768, -32768, -32768}, "/R8");
        apply(1'b1, '{32767, 32767, 32767}, '{-32768, -32768, -32768}, "/R8");
        apply(1'b1, '{-32768, 32767, -32768}, '{32767, -32768, 32767}, "/R8");

        // Reset in mid-stream, then history must start from zero again (R1)
        do_reset();
        apply(1'b1, '{-7, 11, -13}, '{2, 4, 8}, "/R1 after rerun");
        apply(1'b1, '{1, 2, 3}, '{2, 4, 8}, "/R1 follow");
    endtask

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_lane  = '0;
        coef     = '0;
        exp_v    = 1'b0;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule